// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a service line that a processor must keep toggling. Each level change on the line, rising or falling, brings an internal tick counter back to zero. When no change arrives for the number of time-base ticks chosen by a two-bit period select, the block sends a one-cycle timeout pulse to the system reset generator. The service line comes from outside the clock domain, so it first passes through a two-flop synchronizer, and edges are found on the synchronized copy.

The counter advances only on cycles where the time-base tick enable is high. It stays at zero while the reset generator reports that reset is being driven, whatever the cause, and it resumes counting only once that report drops. A separate digital flag from an analog window comparator tells the block that the service line is floating. While that flag is set the watchdog is disabled. When the flag clears, counting starts again from zero.

Top module: `edge_watchdog`

## Requirements
- R1: A rising edge on `svc_in` clears the counter. The clear lands on the third clock edge after the input change: two synchronizer stages, then the edge register.
- R2: A falling edge on `svc_in` clears the counter with the same latency as R1.
- R3: If the counter is not cleared, `wd_expire` pulses on the clock edge of the Nth counted tick after the last clear, where N is the selected limit. A service line held at a constant level therefore times out.
- R4: `period_sel` picks the limit: 0 selects `LIMIT_P0`, 1 selects `LIMIT_P1`, 2 selects `LIMIT_P2` and 3 selects `LIMIT_P3`. Every limit is at least 2.
- R5: The counter advances only in cycles where `tick_en` is high. `wd_expire` is never raised in a cycle that follows a clock edge with `tick_en` low.
- R6: While `rst_hold` is high the counter is zero and no timeout is emitted. After `rst_hold` falls, the first counted tick takes the counter to 1.
- R7: While `svc_float` is high, `wd_expire` stays low.
- R8: When `svc_float` falls, counting restarts from zero, so the next timeout comes N ticks later.
- R9: `wd_expire` is high for exactly one cycle. The counter restarts at zero with that pulse, so an unserviced line times out again every N ticks.
- R10: `svc_in` passes through two synchronizer flops before edge detection.
- R11: The synchronous reset `rst` clears the counter and the synchronizer and holds `wd_expire` low.
- R12: If `period_sel` switches to a limit at or below the current count, the next counted tick emits the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base tick enable; the counter advances on cycles where it is high |
| svc_in | input | 1 | Asynchronous service line from the processor |
| svc_float | input | 1 | High when the service line is detected as floating (watchdog disabled) |
| period_sel | input | 2 | Timeout period select |
| rst_hold | input | 1 | High while the reset generator is driving system reset |
| wd_expire | output | 1 | Registered one-cycle timeout pulse |

## Verification
The bench builds the block with limits of 5, 9, 14 and 22 ticks in place of the long default periods. This makes every period, the repeat spacing between pulses, and a mid-count switch to a shorter period reachable in a few dozen cycles. The short limits also let random service gaps, sparse ticks, hold pulses and floating intervals produce many timeouts within a few thousand cycles. The edge-latency cases toggle the line three ticks into a 9-tick window. The first pulse then falls 15 cycles after release, which separates a two-stage synchronizer from a shorter or longer one.

// File: rtl/edge_wdog_pkg.sv
package edge_wdog_pkg;

  localparam int unsigned NUM_PERIODS = 4;

  typedef logic [1:0] period_sel_t;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdog_svc_sync.sv
module wdog_svc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic svc_in,
  output logic svc_edge
);

  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], svc_in};
  end

  assign svc_edge = pipe_q[STAGES] ^ pipe_q[STAGES-1];

endmodule

// File: rtl/wdog_period_sel.sv
module wdog_period_sel
  import edge_wdog_pkg::*;
#(
  parameter int unsigned LIMIT_P0 = 63,
  parameter int unsigned LIMIT_P1 = 1020,
  parameter int unsigned LIMIT_P2 = 16000,
  parameter int unsigned LIMIT_P3 = 256000,
  parameter int unsigned CNT_W    = 18
) (
  input  period_sel_t      sel,
  output logic [CNT_W-1:0] limit
);

  localparam int unsigned LIMITS [NUM_PERIODS] = '{LIMIT_P0, LIMIT_P1, LIMIT_P2, LIMIT_P3};

  logic [CNT_W-1:0] lim_tab [NUM_PERIODS];

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(LIMITS[g]);
  end

  assign limit = lim_tab[sel];

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             svc_edge,
  input  logic             hold,
  input  logic             float_flag,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             expire_q;
  logic             clear;
  logic             at_limit;

  assign clear    = hold | float_flag | svc_edge;
  assign at_limit = cnt_q >= (limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (clear) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (tick_en) begin
      if (at_limit) begin
        cnt_q    <= '0;
        expire_q <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        expire_q <= 1'b0;
      end
    end else begin
      expire_q <= 1'b0;
    end
  end

  assign expire = expire_q;

  p_edge_clears_r1: assert property (@(posedge clk) disable iff (rst)
    svc_edge |=> (cnt_q == '0));

  p_expire_needs_tick_r5: assert property (@(posedge clk) disable iff (rst)
    expire_q |-> $past(tick_en));

  p_hold_clears_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_q == '0 && !expire_q));

  p_float_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    float_flag |=> !expire_q);

  p_float_restart_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(float_flag) |-> (cnt_q == '0));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    expire_q |-> (cnt_q == '0) ##1 !expire_q);

endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
  import edge_wdog_pkg::*;
#(
  parameter int unsigned LIMIT_P0    = 63,
  parameter int unsigned LIMIT_P1    = 1020,
  parameter int unsigned LIMIT_P2    = 16000,
  parameter int unsigned LIMIT_P3    = 256000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       svc_in,
  input  logic       svc_float,
  input  logic [1:0] period_sel,
  input  logic       rst_hold,
  output logic       wd_expire
);

  localparam int unsigned MAX_LIMIT = max_of4(LIMIT_P0, LIMIT_P1, LIMIT_P2, LIMIT_P3);
  localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

  logic             svc_edge;
  logic [CNT_W-1:0] limit;

  wdog_svc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk      (clk),
    .rst      (rst),
    .svc_in   (svc_in),
    .svc_edge (svc_edge)
  );

  wdog_period_sel #(
    .LIMIT_P0 (LIMIT_P0),
    .LIMIT_P1 (LIMIT_P1),
    .LIMIT_P2 (LIMIT_P2),
    .LIMIT_P3 (LIMIT_P3),
    .CNT_W    (CNT_W)
  ) i_sel (
    .sel   (period_sel),
    .limit (limit)
  );

  wdog_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .svc_edge   (svc_edge),
    .hold       (rst_hold),
    .float_flag (svc_float),
    .limit      (limit),
    .expire     (wd_expire)
  );

  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> !wd_expire);

endmodule

// File: tb/test_edge_watchdog.sv
module test_edge_watchdog;

  localparam int L0 = 5;
  localparam int L1 = 9;
  localparam int L2 = 14;
  localparam int L3 = 22;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       svc = 1'b0;
  logic       flt = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       hold = 1'b0;
  logic       expire;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  edge_watchdog #(
    .LIMIT_P0 (L0),
    .LIMIT_P1 (L1),
    .LIMIT_P2 (L2),
    .LIMIT_P3 (L3)
  ) i_edge_watchdog (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick),
    .svc_in     (svc),
    .svc_float  (flt),
    .period_sel (sel),
    .rst_hold   (hold),
    .wd_expire  (expire)
  );

  function automatic int lim_of(input logic [1:0] s);
    case (s)
      2'd0:    return L0;
      2'd1:    return L1;
      2'd2:    return L2;
      default: return L3;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  logic m_s1, m_s2, m_s3, m_edge, m_exp;
  int   m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_exp = 0;
    end else begin
      m_edge = (m_s2 != m_s3);
      if (hold || flt || m_edge) begin
        m_cnt = 0; m_exp = 0;
      end else if (tick) begin
        if (m_cnt >= lim_of(sel) - 1) begin
          m_cnt = 0; m_exp = 1;
        end else begin
          m_cnt = m_cnt + 1; m_exp = 0;
        end
      end else begin
        m_exp = 0;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = svc;
    end
  end

  bit model_on = 1'b0;
  always @(negedge clk) begin
    if (model_on) chk("R3 R9 model", int'(expire), int'(m_exp));
  end

  task automatic measure(input bit use_float, input logic [1:0] sel0, input int tog_at,
                         input int sel_at, input logic [1:0] sel1, input int exp_first,
                         input string tag);
    int first  = 0;
    int second = 0;
    tick = 1'b1;
    sel  = sel0;
    if (use_float) flt = 1'b1; else hold = 1'b1;
    repeat (5) @(negedge clk);
    flt  = 1'b0;
    hold = 1'b0;
    for (int i = 1; i <= 200 && second == 0; i++) begin
      @(negedge clk);
      if (expire) begin
        if (first == 0) first = i; else second = i;
      end
      if (i == tog_at) svc = ~svc;
      if (i == sel_at) sel = sel1;
    end
    chk(tag, first, exp_first);
    chk("R9 repeat spacing", second - first, lim_of(sel));
  endtask

  task automatic count_pulses(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (expire) n++;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    // R11: reset state
    repeat (4) @(negedge clk);
    chk("R11 reset expire low", int'(expire), 0);
    hold = 1'b1;
    rst  = 1'b0;
    @(negedge clk);
    chk("R11 after reset", int'(expire), 0);
    model_on = 1'b1;

    // R3/R4: each period with constant service line
    measure(0, 2'd0, 0, 0, 2'd0, L0, "R3 R4 sel0");
    measure(0, 2'd1, 0, 0, 2'd0, L1, "R4 sel1");
    measure(0, 2'd2, 0, 0, 2'd0, L2, "R4 sel2");
    measure(0, 2'd3, 0, 0, 2'd0, L3, "R4 sel3");

    // R1/R10: rising edge at tick 3 of a 9-tick window -> pulse at 15
    svc = 1'b0;
    measure(0, 2'd1, 3, 0, 2'd0, 15, "R1 R10 rising");
    // R2: svc is now 1, toggle gives a falling edge
    measure(0, 2'd1, 3, 0, 2'd0, 15, "R2 R10 falling");

    // R12: switch from 22 to 5 ticks with count at 12 -> next tick expires
    measure(0, 2'd3, 0, 12, 2'd0, 13, "R12 shrink limit");

    // R8: floating flag released -> full period from zero
    measure(1, 2'd0, 0, 0, 2'd0, L0, "R8 float release");

    // R6: long hold with ticks yields nothing
    hold = 1'b1;
    count_pulses(100, n);
    chk("R6 hold suppresses", n, 0);
    hold = 1'b0;

    // R5: no ticks, no progress
    tick = 1'b0;
    count_pulses(60, n);
    chk("R5 no tick no expire", n, 0);
    tick = 1'b1;
    count_pulses(L0, n);
    chk("R5 resumes after tick", n, 1);

    // R7: floating line never times out
    flt = 1'b1;
    count_pulses(120, n);
    chk("R7 float quiet", n, 0);
    flt = 1'b0;

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 11) == 0) svc = ~svc;
      if ($urandom_range(0, 79) == 0) hold = ~hold;
      if (hold && $urandom_range(0, 3) == 0) hold = 1'b0;
      if ($urandom_range(0, 149) == 0) flt = ~flt;
      if ($urandom_range(0, 199) == 0) sel = 2'($urandom_range(0, 3));
    end

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule